// File: doc/BRIEF.md
# Disk Controller Phase Status Tracker

This block follows a simplified floppy-style disk controller through its command, execution and result phases. From that state it drives an 8-bit main status value that the host may sample at any moment. The host side has a data-port write strobe with a byte and a data-port read strobe. A stubbed execution engine supplies an execution-done pulse, per-drive seek-start pulses and per-drive seek-done pulses.

A small opcode table fixes how many command bytes each command takes, whether it has an execution phase and how many result bytes it returns. Every status flag is produced from the current phase, so the host can tell when a byte may be moved and in which direction. Accesses the protocol does not allow are dropped, and they set a sticky error flag.

Top module: `disk_phase_status`

## Requirements
- R1: A synchronous active-high reset brings the block to idle with status 0x80, protocol error 0 and DMA (non-polled) mode selected.
- R2: The status bits, from bit 7 down, are request (host may move a byte), direction (1 = host reads, 0 = host writes), polled execution, command busy, and drive 3..0 seek busy. Command busy rises after the first accepted command byte. The opcode is decoded from byte bits 4:0 only: 0x03 specify, 0x0F seek, 0x07 recalibrate, 0x06 read.
- R3: Seek takes 3 bytes and recalibrate takes 2 bytes. Neither has an execution or result phase. Once the last byte is accepted, command busy is 0 and the busy bit of the drive named in byte 2 bits 1:0 is 1.
- R4: Drive busy bit n is set by seek_start[n] and cleared by seek_done[n]. Set wins when both arrive in the same cycle, and each drive is tracked on its own so seeks may overlap.
- R5: Specify takes 3 bytes and returns no results. Bit 0 of its second byte selects polled mode (1) or DMA mode (0) for later commands, and command busy drops after the third byte.
- R6: Read takes 9 bytes and then enters execution. In DMA mode the status during execution is 0x10 (request 0) until exec_done.
- R7: In polled mode the status during execution is 0xF0. Host data reads in that phase are accepted and leave the phase unchanged.
- R8: exec_done in execution starts the result phase with status 0xD0. After exactly 7 accepted reads the status returns to 0x80.
- R9: The following accesses are ignored and set a sticky protocol error flag that only reset clears: a write while direction is 1, a read while direction is 0, any access while request is 0, and simultaneous read and write strobes.
- R10: A first byte whose bits 4:0 match no opcode is ignored, sets the protocol error flag and leaves the block idle.
- R11: exec_done outside the execution phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host data-port write strobe |
| wr_data | input | 8 | Byte written to the data port |
| rd_stb | input | 1 | Host data-port read strobe |
| exec_done | input | 1 | Execution engine finished the execution phase |
| seek_start | input | 4 | Per-drive seek (implied or explicit) begins |
| seek_done | input | 4 | Per-drive seek ends |
| status | output | 8 | Main status value |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The bench walks complete specify, read, seek and recalibrate sequences and checks the status after every byte. It probes the byte where command busy must drop. A tracker that counted one byte too many or too few would leave the status at 0x90 or return to idle early. The bench also checks that the mode bit latched by specify changes the execution status between 0x10 and 0xF0, and that reset clears that mode. Further checks cover a seek-start and seek-done collision on one drive, where a wrong priority would clear the busy bit, and a write during request-low execution, which a careless design would count as a byte or let through without an error.

// File: rtl/disk_phase_status.sv
module disk_phase_status #(
  parameter int LEN_SPEC  = 3,
  parameter int LEN_SEEK  = 3,
  parameter int LEN_RECAL = 2,
  parameter int LEN_READ  = 9,
  parameter int RES_READ  = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       rd_stb,
  input  logic       exec_done,
  input  logic [3:0] seek_start,
  input  logic [3:0] seek_done,
  output logic [7:0] status,
  output logic       proto_err
);
  localparam int CW = $clog2(LEN_READ + 1);
  localparam int RW = $clog2(RES_READ + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_t;
  typedef enum logic [2:0] {OP_NONE, OP_SPEC, OP_SEEK, OP_RECAL, OP_READ} op_t;

  phase_t        phase;
  op_t           op;
  logic [CW-1:0] bcnt;
  logic [RW-1:0] rcnt;
  logic [7:0]    arg;
  logic          polled;
  logic [3:0]    dbsy;

  op_t           new_op;
  logic [CW-1:0] op_len;
  logic [7:0]    cur_arg;
  logic          rqm, dio, ndma, cb;
  logic          wr_ok, rd_ok, bad, last;
  logic [3:0]    cmd_seek;

  always_comb begin
    unique case (wr_data[4:0])
      5'h03:   new_op = OP_SPEC;
      5'h0F:   new_op = OP_SEEK;
      5'h07:   new_op = OP_RECAL;
      5'h06:   new_op = OP_READ;
      default: new_op = OP_NONE;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_SPEC:  op_len = CW'(LEN_SPEC);
      OP_SEEK:  op_len = CW'(LEN_SEEK);
      OP_RECAL: op_len = CW'(LEN_RECAL);
      OP_READ:  op_len = CW'(LEN_READ);
      default:  op_len = '0;
    endcase
  end

  assign rqm  = (phase != PH_EXEC) || polled;
  assign dio  = (phase == PH_RES) || (phase == PH_EXEC && polled);
  assign ndma = (phase == PH_EXEC) && polled;
  assign cb   = (phase != PH_IDLE);
  assign status = {rqm, dio, ndma, cb, dbsy};

  assign wr_ok   = wr_stb && !rd_stb && rqm && !dio;
  assign rd_ok   = rd_stb && !wr_stb && rqm && dio;
  assign bad     = ((wr_stb || rd_stb) && !(wr_ok || rd_ok)) ||
                   (wr_ok && phase == PH_IDLE && new_op == OP_NONE);
  assign cur_arg = (bcnt == CW'(1)) ? wr_data : arg;
  assign last    = (bcnt + CW'(1)) == op_len;
  assign cmd_seek = (phase == PH_CMD && wr_ok && last && (op == OP_SEEK || op == OP_RECAL))
                    ? (4'b0001 << cur_arg[1:0]) : 4'b0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      op        <= OP_NONE;
      bcnt      <= '0;
      rcnt      <= '0;
      arg       <= '0;
      polled    <= 1'b0;
      dbsy      <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= proto_err | bad;
      dbsy      <= (dbsy & ~seek_done) | seek_start | cmd_seek;
      unique case (phase)
        PH_IDLE:
          if (wr_ok && new_op != OP_NONE) begin
            op    <= new_op;
            bcnt  <= CW'(1);
            phase <= PH_CMD;
          end
        PH_CMD:
          if (wr_ok) begin
            if (bcnt == CW'(1)) arg <= wr_data;
            if (last) begin
              bcnt <= '0;
              if (op == OP_READ) phase <= PH_EXEC;
              else               phase <= PH_IDLE;
              if (op == OP_SPEC) polled <= cur_arg[0];
            end else begin
              bcnt <= bcnt + CW'(1);
            end
          end
        PH_EXEC:
          if (exec_done) begin
            phase <= PH_RES;
            rcnt  <= RW'(RES_READ);
          end
        PH_RES:
          if (rd_ok) begin
            if (rcnt == RW'(1)) phase <= PH_IDLE;
            else                rcnt  <= rcnt - RW'(1);
          end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_ndma_exec_r7: assert property (@(posedge clk) disable iff (rst)
    status[5] |-> (status[7] && status[6] && status[4]));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  p_rqm_low_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    ((wr_stb || rd_stb) && !status[7] && !exec_done) |=> ($stable(status[7:4]) && proto_err));

  p_seek_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ((|(seek_done & ~seek_start)) && !wr_stb) |=>
      ((status[3:0] & $past(seek_done & ~seek_start)) == 4'b0000));

  p_seek_set_r4: assert property (@(posedge clk) disable iff (rst)
    (|seek_start) |=> ((status[3:0] & $past(seek_start)) == $past(seek_start)));

  p_cb_first_r2: assert property (@(posedge clk) disable iff (rst)
    (!status[4] && wr_stb && !rd_stb && new_op != OP_NONE) |=> status[4]);

  p_res_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RES && rd_ok && rcnt == RW'(1)) |=> (status[7:4] == 4'h8));

  p_exec_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (exec_done && !status[4] && !wr_stb && !rd_stb) |=> !status[4]);
endmodule

// File: tb/test_disk_phase_status.sv
module test_disk_phase_status;
  localparam int PERIOD = 10;
  localparam int NV = 25;
  // kind[17:16]: 0 write, 1 read, 2 exec_done ; data[15:8] ; expected status[7:0]
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h03, 8'h90}, {2'd0, 8'h00, 8'h90}, {2'd0, 8'h00, 8'h80},
    {2'd0, 8'hE6, 8'h90}, {2'd0, 8'h00, 8'h90}, {2'd0, 8'h00, 8'h90},
    {2'd0, 8'h00, 8'h90}, {2'd0, 8'h00, 8'h90}, {2'd0, 8'h00, 8'h90},
    {2'd0, 8'h00, 8'h90}, {2'd0, 8'h00, 8'h90}, {2'd0, 8'h00, 8'h10},
    {2'd2, 8'h00, 8'hD0}, {2'd1, 8'h00, 8'hD0}, {2'd1, 8'h00, 8'hD0},
    {2'd1, 8'h00, 8'hD0}, {2'd1, 8'h00, 8'hD0}, {2'd1, 8'h00, 8'hD0},
    {2'd1, 8'h00, 8'hD0}, {2'd1, 8'h00, 8'h80},
    {2'd0, 8'h0F, 8'h90}, {2'd0, 8'h02, 8'h90}, {2'd0, 8'h00, 8'h84},
    {2'd0, 8'h07, 8'h94}, {2'd0, 8'h01, 8'h86}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0, rd_stb = 1'b0, exec_done = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] seek_start = 4'h0, seek_done = 4'h0;
  logic [7:0] status;
  logic       proto_err;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  disk_phase_status i_disk_phase_status (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .exec_done(exec_done), .seek_start(seek_start), .seek_done(seek_done),
    .status(status), .proto_err(proto_err));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] kind, input logic [7:0] d);
    @(negedge clk);
    wr_stb    = (kind == 2'd0);
    rd_stb    = (kind == 2'd1);
    exec_done = (kind == 2'd2);
    wr_data   = d;
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; exec_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic read_cmd();
    step(2'd0, 8'h06);
    for (int i = 0; i < 8; i++) step(2'd0, 8'h00);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset err", {7'd0, proto_err}, 8'h00);

    // R2 R3 R5 R6 R8 table walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][17:16], VEC[v][15:8]);
      chk("R2/R3/R5/R6/R8 vector", status, VEC[v][7:0]);
    end
    chk("R9 no error on legal traffic", {7'd0, proto_err}, 8'h00);

    // R4 per-drive clear, then collision on drive 0
    @(negedge clk); seek_done = 4'b0100; @(negedge clk); seek_done = 4'h0;
    chk("R4 drive 2 cleared", status, 8'h82);
    @(negedge clk); seek_start = 4'b0001; seek_done = 4'b0011;
    @(negedge clk); seek_start = 4'h0; seek_done = 4'h0;
    chk("R4 set wins, drive 1 cleared", status, 8'h81);
    @(negedge clk); seek_done = 4'b0001; @(negedge clk); seek_done = 4'h0;
    chk("R4 all clear", status, 8'h80);

    // R11 exec_done in idle
    step(2'd2, 8'h00);
    chk("R11 exec_done idle", status, 8'h80);

    // R9 write during DMA execution
    read_cmd();
    chk("R6 dma exec", status, 8'h10);
    step(2'd0, 8'h55);
    chk("R9 write with request low", status, 8'h10);
    chk("R9 err set", {7'd0, proto_err}, 8'h01);
    step(2'd2, 8'h00);
    step(2'd0, 8'h00);
    chk("R9 write in result phase", status, 8'hD0);
    chk("R9 err sticky", {7'd0, proto_err}, 8'h01);

    // R5 R7 polled mode
    do_reset();
    step(2'd0, 8'h03); step(2'd0, 8'h01); step(2'd0, 8'h00);
    chk("R5 specify done", status, 8'h80);
    read_cmd();
    chk("R7 polled exec", status, 8'hF0);
    step(2'd1, 8'h00);
    chk("R7 read in exec", status, 8'hF0);
    step(2'd2, 8'h00);
    chk("R8 result entry", status, 8'hD0);
    for (int i = 0; i < 7; i++) step(2'd1, 8'h00);
    chk("R8 result exit", status, 8'h80);
    chk("R7 no err", {7'd0, proto_err}, 8'h00);

    // R1 reset clears polled mode
    do_reset();
    read_cmd();
    chk("R1 mode cleared", status, 8'h10);

    // R10 unknown opcode, R9 read while direction write
    do_reset();
    step(2'd0, 8'h1F);
    chk("R10 unknown idle", status, 8'h80);
    chk("R10 err", {7'd0, proto_err}, 8'h01);
    do_reset();
    step(2'd1, 8'h00);
    chk("R9 read while write dir", status, 8'h80);
    chk("R9 read err", {7'd0, proto_err}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule